// File: doc/BRIEF.md
# Watchdog Timer with Timed Reconfiguration Lock

This block is a watchdog timer. A free-running prescaler produces ticks, and a timeout counter counts those ticks. When the counter reaches a limit chosen by a 3-bit period field, the block drives a one-cycle reset request and the counter starts again. Software keeps the system alive by pulsing a kick strobe, which returns the counter to zero.

Software reaches the control register through a write strobe and a data word. The word holds a change-unlock bit, an enable bit and the period field. A read-only status word shows the same three fields. A plain write cannot change the period. To change it, software must first write the unlock bit and the enable bit as one in the same write. Within the next four clock cycles it must then make a second write that carries the new period with the unlock bit cleared. Outside that window the unlock bit clears itself. A static safety input selects an always-on mode. In that mode the watchdog cannot be turned off, the enable bit always reads as one, and any enable value in a write is ignored.

Top module: `wdt_guard`

## Requirements
- R1: After a synchronous reset with the safety input low, the status word reads zero and the reset request is low. The status layout is bit 4 = unlock, bit 3 = enable, bits 2:0 = period, and the write word uses the same positions.
- R2: With the safety input high, status bit 3 reads one at all times, the watchdog counts without any write, and a write with bit 3 cleared never disables it.
- R3: A write with bit 4 clear that arrives while the window is closed leaves the period field unchanged.
- R4: A write with bits 4 and 3 both set opens a window: status bit 4 reads one from the next cycle, and the period does not change.
- R5: A write with bit 4 clear, captured on any of the four clock edges after the opening write, loads the period from bits 2:0. Outside safety mode it also loads the enable bit from bit 3. This write closes the window.
- R6: If no accepted second write arrives, the window closes by itself after the fourth edge. A later write, or a write inside the window with bit 4 set, does not change the period.
- R7: The timeout is 2^(BASE_EXP+n) prescaler ticks, where n is the period field. The reset request lasts exactly one cycle, the counter restarts, and consecutive requests are that many ticks apart.
- R8: A kick clears the counter. The next request comes exactly one full timeout after the kick edge, and regular kicks at shorter intervals prevent any request.
- R9: Outside safety mode, any write with bit 3 set turns the enable on. Only the timed sequence can turn it off, and while it is off no reset request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| safety_mode_i | input | 1 | Static always-on mode select |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | PS_W+2 | Write data {unlock, enable, period} |
| kick_i | input | 1 | Watchdog clear strobe |
| status_o | output | PS_W+2 | Status view {unlock, enable, period} |
| wdt_rst_o | output | 1 | One-cycle timeout reset request |

## Verification
The assertions check several rules on every cycle:
- The period field never changes while the window is closed.
- Outside a window the enable bit never falls.
- The window always closes after its last cycle.
- The reset request is a single cycle.
- The reset request stays low after a kick or while the watchdog is disabled.
- In safety mode the enable bit reads as one.

Only the bench scenarios show the remaining behaviour. These are the exact timeout lengths for each period code, the window boundary (a second write on the fourth edge is accepted, on the fifth it is not), the kick-to-request distance, and the fact that regular kicking prevents any request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  parameter int unsigned WDT_PS_W = 3;

  typedef struct packed {
    logic                unlock;
    logic                enable;
    logic [WDT_PS_W-1:0] period;
  } wdt_ctrl_t;

  localparam int unsigned WDT_CTRL_W = $bits(wdt_ctrl_t);
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_DIV = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      always_ff @(posedge clk) begin
        if (rst) tick_o <= 1'b0;
        else     tick_o <= 1'b1;
      end
    end else begin : g_div
      localparam int unsigned DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          div_q  <= '0;
          tick_o <= 1'b0;
        end else if (div_q == DW'(TICK_DIV - 1)) begin
          div_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          div_q  <= div_q + DW'(1);
          tick_o <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                safety_i,
  input  logic                wr_en_i,
  input  wdt_ctrl_t           wr_data_i,
  output logic                en_o,
  output logic [WDT_PS_W-1:0] period_o,
  output logic                unlock_o
);
  localparam int unsigned WW = $clog2(WIN_CYC + 1);

  logic                unlock_q;
  logic                en_q;
  logic [WDT_PS_W-1:0] period_q;
  logic [WW-1:0]       win_q;
  logic                open_wr;
  logic                second_wr;

  assign open_wr   = wr_en_i && wr_data_i.unlock && wr_data_i.enable;
  assign second_wr = wr_en_i && !wr_data_i.unlock;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock_q <= 1'b0;
      en_q     <= 1'b0;
      period_q <= '0;
      win_q    <= '0;
    end else if (open_wr) begin
      unlock_q <= 1'b1;
      en_q     <= 1'b1;
      win_q    <= WW'(WIN_CYC);
    end else if (unlock_q) begin
      if (second_wr) begin
        period_q <= wr_data_i.period;
        if (!safety_i) en_q <= wr_data_i.enable;
        unlock_q <= 1'b0;
        win_q    <= '0;
      end else if (win_q == WW'(1)) begin
        unlock_q <= 1'b0;
        win_q    <= '0;
      end else begin
        win_q <= win_q - WW'(1);
      end
    end else if (second_wr && wr_data_i.enable) begin
      en_q <= 1'b1;
    end
  end

  assign en_o     = en_q | safety_i;
  assign period_o = period_q;
  assign unlock_o = unlock_q;

  AST_PERIOD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !unlock_q |=> period_q == $past(period_q)); // R3
  AST_EN_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (en_q && !unlock_q) |=> en_q); // R9
  AST_WIN_EXPIRES: assert property (@(posedge clk) disable iff (rst)
    (unlock_q && win_q == WW'(1) && !open_wr) |=> !unlock_q); // R6
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic                tick_i,
  input  logic                kick_i,
  input  logic [WDT_PS_W-1:0] period_i,
  output logic                pulse_o
);
  localparam int unsigned CNT_W = BASE_EXP + (1 << WDT_PS_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim_m1;

  assign lim_m1 = ((CNT_W+1)'(1) << (BASE_EXP + int'(period_i))) - (CNT_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst || !en_i || kick_i) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (tick_i) begin
      if ({1'b0, cnt_q} >= lim_m1) begin
        cnt_q   <= '0;
        pulse_o <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + CNT_W'(1);
        pulse_o <= 1'b0;
      end
    end else begin
      pulse_o <= 1'b0;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o); // R7
  AST_KICK_QUIET: assert property (@(posedge clk) disable iff (rst)
    kick_i |=> !pulse_o); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !pulse_o); // R9
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1024,
  parameter int unsigned BASE_EXP = 14,
  parameter int unsigned WIN_CYC  = 4,
  localparam int unsigned PS_W    = WDT_PS_W,
  localparam int unsigned CW      = WDT_CTRL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          safety_mode_i,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          kick_i,
  output logic [CW-1:0] status_o,
  output logic          wdt_rst_o
);
  logic            tick;
  logic            en;
  logic            unlock;
  logic [PS_W-1:0] period;
  wdt_ctrl_t       wr_word;

  assign wr_word = wdt_ctrl_t'(wr_data_i);

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  wdt_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .safety_i(safety_mode_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_word), .en_o(en), .period_o(period), .unlock_o(unlock)
  );

  wdt_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
    .clk(clk), .rst(rst), .en_i(en), .tick_i(tick), .kick_i(kick_i),
    .period_i(period), .pulse_o(wdt_rst_o)
  );

  assign status_o = {unlock, en, period};

  AST_SAFETY_EN_READS_ONE: assert property (@(posedge clk) disable iff (rst)
    safety_mode_i |-> status_o[PS_W]); // R2
endmodule

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       safety = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic       kick = 1'b0;
  logic [4:0] status;
  logic       wdt_rst;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_guard #(.TICK_DIV(1), .BASE_EXP(BASE), .WIN_CYC(4)) dut (
    .clk(clk), .rst(rst), .safety_mode_i(safety), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .kick_i(kick), .status_o(status), .wdt_rst_o(wdt_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit u, input bit e, input int p);
    wr_en = 1'b1;
    wr_data = {u, e, 3'(p)};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input bit s);
    rst = 1'b1;
    safety = s;
    idle(3);
    rst = 1'b0;
    idle(2);
  endtask

  // cycles from a kick edge to the next request
  task automatic kick_dist(output int n);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    n = 0;
    while (!wdt_rst && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // cycles between two consecutive requests
  task automatic period_meas(output int n);
    int g = 0;
    while (!wdt_rst && g < 5000) begin
      @(negedge clk);
      g++;
    end
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wdt_rst && n < 5000);
  endtask

  task automatic quiet_for(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst) seen++;
    end
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R1 status", status, 0);
    chk("R1 rst_o", wdt_rst, 0);
  endtask

  task automatic t_disabled;
    int s;
    quiet_for(200, s);
    chk("R9 off no pulse", s, 0);
  endtask

  task automatic t_enable_plain;
    int d;
    wr(1'b0, 1'b1, 5);
    chk("R9 plain enable", status, 5'b01000);
    chk("R3 plain period ignored", status[2:0], 0);
    kick_dist(d);
    chk("R8 kick distance n=0", d, 16);
    idle(1);
    chk("R7 one-cycle pulse", wdt_rst, 0);
    period_meas(d);
    chk("R7 period n=0", d, 16);
  endtask

  task automatic t_sequence;
    int d;
    wr(1'b1, 1'b1, 6);
    chk("R4 unlock visible", status, 5'b11000);
    wr(1'b0, 1'b1, 2);
    chk("R5 period loaded", status, 5'b01010);
    period_meas(d);
    chk("R7 period n=2", d, 64);
    kick_dist(d);
    chk("R8 kick distance n=2", d, 64);
  endtask

  task automatic t_window_edge;
    int d;
    wr(1'b1, 1'b1, 0);
    idle(3);
    wr(1'b0, 1'b1, 3);
    chk("R5 fourth edge accepted", status, 5'b01011);
    wr(1'b1, 1'b1, 0);
    idle(4);
    chk("R6 window self-closed", status[4], 0);
    wr(1'b0, 1'b1, 1);
    chk("R6 late write ignored", status[2:0], 3);
    wr(1'b1, 1'b1, 0);
    wr(1'b1, 1'b0, 6);
    chk("R6 unlock-set write not accepted", status[2:0], 3);
    idle(5);
    period_meas(d);
    chk("R7 period n=3", d, 128);
  endtask

  task automatic t_kick_hold;
    int s = 0;
    for (int i = 0; i < 30; i++) begin
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      idle(100);
      if (wdt_rst) s++;
    end
    chk("R8 regular kicks hold off", s, 0);
  endtask

  task automatic t_disable_seq;
    int s;
    wr(1'b0, 1'b0, 0);
    chk("R9 plain clear ignored", status[3], 1);
    wr(1'b1, 1'b1, 0);
    wr(1'b0, 1'b0, 3);
    chk("R9 sequence clears enable", status, 5'b00011);
    quiet_for(300, s);
    chk("R9 no pulse when off", s, 0);
  endtask

  task automatic t_safety;
    int d;
    do_reset(1'b1);
    chk("R2 enable reads one", status, 5'b01000);
    period_meas(d);
    chk("R2 counts without write", d, 16);
    wr(1'b0, 1'b0, 4);
    chk("R2 plain clear ignored", status, 5'b01000);
    wr(1'b1, 1'b1, 0);
    wr(1'b0, 1'b0, 5);
    chk("R5 safety period loaded", status[2:0], 5);
    chk("R2 enable held in sequence", status[3], 1);
    period_meas(d);
    chk("R7 period n=5", d, 512);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_disabled();
    t_enable_plain();
    t_sequence();
    t_window_edge();
    t_kick_hold();
    t_disable_seq();
    t_safety();
    finish_run();
  end
endmodule